// File: doc/BRIEF.md
# Streaming 3x3 Signed Convolution Filter

This block filters a square grayscale image that arrives as a stream of 8-bit pixels, at most one per clock, in raster order (left to right within a row, rows top to bottom). Two line stores keep the two previous rows. Together with a 3x3 register array they form the neighbourhood of the newest pixel. Each complete neighbourhood passes through a six-stage pipeline. The pipeline multiplies the nine pixels by nine signed coefficients, adds the products, shifts the sum right by a programmable amount and clamps it to the pixel range. The block emits one filtered pixel per clock, together with a sequential store address.

Software loads the nine coefficients and the shift amount before a frame and holds them for the whole frame. The image edge length, 64 or 128, is chosen with one select input. A one-cycle frame-start pulse, sent between frames, realigns the row and column position and restarts the address sequence. Windows that would reach past the image border produce no output, so a frame of edge W gives (W-2)x(W-2) results.

Top module: `conv3x3_stream`

## Requirements
- R1: A cycle with `coef_we` high writes `coef_data` into kernel entry `coef_idx`. Entry k = 3*r + c, where r=0 is the oldest of the three rows and c=0 is the leftmost column. Writes with `coef_idx` from 9 to 15 change no coefficient.
- R2: A pixel is taken on each rising edge where `pix_valid` is high. Cycles with `pix_valid` low advance nothing, so gaps in the stream do not change any result.
- R3: `size_sel` = 0 selects a 64x64 image and `size_sel` = 1 selects a 128x128 image. The value sets where each row wraps.
- R4: A result is produced only for a window whose newest pixel has column index >= 2 and row index >= 2, counting from 0. A full frame gives exactly (W-2)^2 results, in the raster order of those newest pixels.
- R5: The result is built from the signed sum over r,c of coef[3r+c] * P(y-2+r, x-2+c), where (y,x) is the newest pixel. Pixels are treated as unsigned (zero-extended) and coefficients as 8-bit two's complement.
- R6: The sum is arithmetically shifted right by `shift_amt` (0 to 7), which rounds toward minus infinity.
- R7: The shifted value is clamped: below 0 gives 0, above 255 gives 255, and any other value passes unchanged.
- R8: `out_valid` rises for a window exactly six rising edges after the edge that takes that window's newest pixel. `out_valid` is never high without such a window.
- R9: `out_addr` is 0 for the first result after `frame_start` and goes up by one for each further result. It changes only together with `out_valid`.
- R10: A `frame_start` pulse returns the row and column position to 0, so a frame cut short by a new `frame_start` does not disturb the next frame.
- R11: While reset is active and right after it, `out_valid`, `out_pix` and `out_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse before the first pixel of a frame |
| pix_valid | input | 1 | Pixel strobe |
| pix_in | input | 8 | Unsigned grayscale pixel |
| size_sel | input | 1 | 0: 64x64, 1: 128x128 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Coefficient entry, 3*row + column |
| coef_data | input | 8 | Signed coefficient value |
| shift_amt | input | 3 | Right-shift applied to the sum |
| out_pix | output | 8 | Filtered pixel |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 14 | Store address of the result |

## Verification
An identity kernel on random pixels checks that the window taps line up with the image, because any row or column slip shows as a wrong pixel. Random kernels with random shifts, fed in both image sizes and with random gaps in the stream, check the signed products, the flooring shift and stall handling against a bench model. Uniform frames of full-white pixels with extreme positive and negative kernels drive the clamp to both of its limits. A frame cut short and followed by a new start shows whether the position counters and the address counter really restart.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int unsigned KDIM  = 3;
  localparam int unsigned NTAPS = KDIM * KDIM;

  typedef enum logic {
    SIZE_SMALL = 1'b0,
    SIZE_LARGE = 1'b1
  } img_size_e;
endpackage

// File: rtl/conv_window.sv
module conv_window
  import conv_pkg::*;
#(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned MAX_W   = 128,
  parameter int unsigned SMALL_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start,
  input  logic                         pix_valid,
  input  logic [PIX_W-1:0]             pix_in,
  input  logic                         size_sel,
  output logic                         win_valid,
  output logic [NTAPS-1:0][PIX_W-1:0]  win
);
  localparam int unsigned CW = $clog2(MAX_W);

  logic [CW-1:0]    col_q, col_d, row_q, row_d, last_idx;
  logic             win_valid_d, take;
  logic [PIX_W-1:0] line_a [MAX_W];
  logic [PIX_W-1:0] line_b [MAX_W];
  logic [KDIM-1:0][PIX_W-1:0] newcol;

  assign take     = pix_valid && !frame_start;
  assign last_idx = (img_size_e'(size_sel) == SIZE_LARGE) ? CW'(MAX_W - 1) : CW'(SMALL_W - 1);

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (frame_start) begin
      col_d = '0;
      row_d = '0;
    end else if (pix_valid) begin
      if (col_q == last_idx) begin
        col_d = '0;
        row_d = (row_q == last_idx) ? '0 : row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
    win_valid_d = take && (col_q >= CW'(2)) && (row_q >= CW'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      row_q     <= '0;
      win_valid <= 1'b0;
    end else begin
      col_q     <= col_d;
      row_q     <= row_d;
      win_valid <= win_valid_d;
    end
  end

  // Line stores: each holds one row, addressed by column.
  always_ff @(posedge clk) begin
    if (take) begin
      line_b[col_q] <= line_a[col_q];
      line_a[col_q] <= pix_in;
    end
  end

  assign newcol[0] = line_b[col_q];
  assign newcol[1] = line_a[col_q];
  assign newcol[2] = pix_in;

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (take) begin
        win[r*KDIM + 0] <= win[r*KDIM + 1];
        win[r*KDIM + 1] <= win[r*KDIM + 2];
        win[r*KDIM + 2] <= newcol[r];
      end
    end
  end
endmodule

// File: rtl/conv_mac.sv
module conv_mac
  import conv_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned SH_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [NTAPS-1:0][PIX_W-1:0]  win,
  input  logic [NTAPS-1:0][COEF_W-1:0] coef,
  input  logic [SH_W-1:0]              shift_amt,
  output logic                         res_valid,
  output logic [PIX_W-1:0]             res_pix
);
  localparam int unsigned PW = PIX_W + COEF_W + 1;
  localparam int unsigned RW = PW + 2;
  localparam int unsigned SW = PW + 4;
  localparam logic signed [SW-1:0] PIX_MAX = SW'((1 << PIX_W) - 1);

  logic [4:0]              vld_q;
  logic signed [PW-1:0]    prod_d [NTAPS];
  logic signed [PW-1:0]    prod_q [NTAPS];
  logic signed [RW-1:0]    rsum_d [KDIM];
  logic signed [RW-1:0]    rsum_q [KDIM];
  logic signed [SW-1:0]    sum_d, sum_q, sh_d, sh_q;
  logic [PIX_W-1:0]        sat_d;

  always_comb begin
    for (int t = 0; t < NTAPS; t++) begin
      prod_d[t] = $signed({{(PW-PIX_W){1'b0}}, win[t]}) *
                  $signed({{(PW-COEF_W){coef[t][COEF_W-1]}}, coef[t]});
    end
    for (int r = 0; r < KDIM; r++) begin
      rsum_d[r] = RW'(prod_q[r*KDIM]) + RW'(prod_q[r*KDIM+1]) + RW'(prod_q[r*KDIM+2]);
    end
    sum_d = SW'(rsum_q[0]) + SW'(rsum_q[1]) + SW'(rsum_q[2]);
    sh_d  = sum_q >>> shift_amt;
    if (sh_q[SW-1])         sat_d = '0;
    else if (sh_q > PIX_MAX) sat_d = '1;
    else                    sat_d = sh_q[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[3:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) prod_q <= prod_d;
    if (vld_q[0]) rsum_q <= rsum_d;
    if (vld_q[1]) sum_q  <= sum_d;
    if (vld_q[2]) sh_q   <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_pix <= '0;
    else if (vld_q[3]) res_pix <= sat_d;
  end

  assign res_valid = vld_q[4];
endmodule

// File: rtl/conv_outaddr.sv
module conv_outaddr #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_start)   cnt_d = '0;
    else if (in_valid) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_addr  <= '0;
    end else begin
      cnt_q     <= cnt_d;
      out_valid <= in_valid;
      if (in_valid) begin
        out_pix  <= in_pix;
        out_addr <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv_pkg::*;
#(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned COEF_W  = 8,
  parameter int unsigned SH_W    = 3,
  parameter int unsigned MAX_W   = 128,
  parameter int unsigned SMALL_W = 64,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned ADDR_W  = $clog2((MAX_W-2)*(MAX_W-2))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              size_sel,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [COEF_W-1:0] coef_data,
  input  logic [SH_W-1:0]   shift_amt,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_ok_n;
  logic [NTAPS-1:0][COEF_W-1:0] coef_q, coef_d;
  logic [NTAPS-1:0][PIX_W-1:0]  win;
  logic                         win_valid, res_valid;
  logic [PIX_W-1:0]             res_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  always_comb begin
    coef_d = coef_q;
    if (coef_we && (coef_idx < IDX_W'(NTAPS))) coef_d[coef_idx] = coef_data;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) coef_q <= '0;
    else           coef_q <= coef_d;
  end

  conv_window #(.PIX_W(PIX_W), .MAX_W(MAX_W), .SMALL_W(SMALL_W)) u_window (
    .clk(clk), .rst_n(rst_ok_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_in(pix_in), .size_sel(size_sel), .win_valid(win_valid), .win(win)
  );

  conv_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .SH_W(SH_W)) u_mac (
    .clk(clk), .rst_n(rst_ok_n), .in_valid(win_valid), .win(win), .coef(coef_q),
    .shift_amt(shift_amt), .res_valid(res_valid), .res_pix(res_pix)
  );

  conv_outaddr #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_ok_n), .frame_start(frame_start), .in_valid(res_valid),
    .in_pix(res_pix), .out_valid(out_valid), .out_pix(out_pix), .out_addr(out_addr)
  );
endmodule

// File: rtl/conv3x3_checker.sv
module conv3x3_checker #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              win_valid,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr
);
  assert_win_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ##6 out_valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> ##6 !out_valid);

  assert_addr_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_addr) |-> out_valid);

  assert_win_needs_pixel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(pix_valid));

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !win_valid);
endmodule

bind conv3x3_stream conv3x3_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_ok_n), .pix_valid(pix_valid), .win_valid(win_valid),
  .out_valid(out_valid), .out_addr(out_addr)
);

// File: tb/test_conv3x3_stream.sv
module test_conv3x3_stream;
  logic       clk = 1'b0;
  logic       rst_n, frame_start, pix_valid, size_sel, coef_we;
  logic [7:0] pix_in, coef_data;
  logic [3:0] coef_idx;
  logic [2:0] shift_amt;
  logic [7:0] out_pix;
  logic       out_valid;
  logic [13:0] out_addr;

  int img [16384];
  int expv [16384];
  int acc_edge [16384];
  int kc [9];
  int exp_n, acc_n, out_n, cyc, n_chk, n_fail, sh;
  string tag;

  always #2.5 clk = ~clk;

  conv3x3_stream i_conv3x3_stream (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_in(pix_in), .size_sel(size_sel), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_data(coef_data), .shift_amt(shift_amt), .out_pix(out_pix),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expct);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expct);
    end
  endtask

  // Output monitor: value (R5/R6/R7 via tag), address R9, latency R8, count R4
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_n >= exp_n) begin
        check(0, "R4 extra output", out_n, exp_n);
      end else begin
        check(int'(out_pix) == expv[out_n], tag, int'(out_pix), expv[out_n]);
        check(int'(out_addr) == out_n, "R9 address", int'(out_addr), out_n);
        check(cyc == acc_edge[out_n] + 6, "R8 latency", cyc, acc_edge[out_n] + 6);
      end
      out_n++;
    end
  end

  function automatic int model(input int w, input int y, input int x);
    int s = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        s += kc[r*3+c] * img[(y-2+r)*w + (x-2+c)];
    s = s >>> sh;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic load_coefs();
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_idx = 4'(k); coef_data = 8'(kc[k]);
    end
    @(negedge clk);
    coef_we = 1'b0;
    shift_amt = 3'(sh);
  endtask

  task automatic run_frame(input bit big, input int gap_pct, input int npix);
    int w = big ? 128 : 64;
    exp_n = 0;
    for (int y = 2; y < w; y++)
      for (int x = 2; x < w; x++)
        if (y*w + x < npix) begin
          expv[exp_n] = model(w, y, x);
          exp_n++;
        end
    @(negedge clk);
    size_sel = big;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    out_n = 0; acc_n = 0;
    for (int p = 0; p < npix; p++) begin
      while ($urandom_range(99) < gap_pct) begin
        pix_valid = 1'b0;
        @(negedge clk);
      end
      pix_valid = 1'b1;
      pix_in = 8'(img[p]);
      if ((p / w) >= 2 && (p % w) >= 2) begin
        acc_edge[acc_n] = cyc + 1;
        acc_n++;
      end
      @(negedge clk);
    end
    pix_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(out_n == exp_n, "R4 result count", out_n, exp_n);
  endtask

  task automatic rand_img(input int n);
    for (int i = 0; i < n; i++) img[i] = int'($urandom_range(255));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    n_chk = 0; n_fail = 0; exp_n = 0; out_n = 0;
    rst_n = 1'b0; frame_start = 1'b0; pix_valid = 1'b0; size_sel = 1'b0;
    coef_we = 1'b0; coef_idx = '0; coef_data = '0; pix_in = '0; shift_amt = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_addr == 0 && out_pix == 0, "R11 reset outputs",
          int'(out_valid) + int'(out_addr) + int'(out_pix), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_addr == 0, "R11 after release", int'(out_addr), 0);

    // R1: identity kernel; writes to entries 9..15 must not alter it
    for (int k = 0; k < 9; k++) kc[k] = (k == 4) ? 1 : 0;
    sh = 0;
    load_coefs();
    for (int k = 9; k < 16; k++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_idx = 4'(k); coef_data = 8'h7f;
    end
    @(negedge clk);
    coef_we = 1'b0;
    tag = "R1 identity kernel";
    rand_img(4096);
    run_frame(1'b0, 0, 4096);

    // R2/R5/R6: random kernel and shift, stream with gaps
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 9; k++) kc[k] = int'($urandom_range(32)) - 16;
      sh = int'($urandom_range(7));
      load_coefs();
      rand_img(4096);
      tag = "R2 R5 R6 gapped stream";
      run_frame(1'b0, 30, 4096);
    end

    // R10: abort part way, then a full frame must be correct
    tag = "R10 cut frame";
    rand_img(4096);
    run_frame(1'b0, 0, 1000);
    tag = "R10 frame after cut";
    run_frame(1'b0, 0, 4096);

    // R3: large image, random kernel, shift 3 flooring
    for (int k = 0; k < 9; k++) kc[k] = int'($urandom_range(20)) - 6;
    sh = 3;
    load_coefs();
    rand_img(16384);
    tag = "R3 R6 128x128";
    run_frame(1'b1, 0, 16384);

    // R7: clamp high and low
    for (int i = 0; i < 4096; i++) img[i] = 255;
    for (int k = 0; k < 9; k++) kc[k] = 127;
    sh = 0;
    load_coefs();
    tag = "R7 clamp high";
    run_frame(1'b0, 0, 4096);
    check(expv[0] == 255, "R7 model high", expv[0], 255);
    for (int k = 0; k < 9; k++) kc[k] = -128;
    sh = 7;
    load_coefs();
    tag = "R7 clamp low";
    run_frame(1'b0, 0, 4096);
    check(expv[0] == 0, "R7 model low", expv[0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule